// File: doc/BRIEF.md
# Transmit Zero-Cross Monitor

This block watches the words that an audio serial transmitter loads into its shift buffer and reports zero crossings separately for the left and right channels. Each loaded word comes with a channel tag. The block compares the sign of the new sample with the sign of the last sample of the same channel. It raises a channel flag when that sign changes. It also raises the flag when every bit inside the selected word width is zero.

A word-width code selects where the sign bit sits: 8, 16, 24 or 32 bits. Detection is enabled per channel. The two flags are sticky and are cleared by a write-1 pulse. A single interrupt line combines each flag with its own interrupt enable. The block only observes transmit data: it neither shifts nor stores samples beyond the one sign bit kept per channel.

Top module: `txzc_monitor`

## Requirements
- R1: After synchronous reset, both flags, the interrupt output and both stored previous signs are 0.
- R2: On a load with detection enabled for that channel, the channel flag is 1 in the cycle after the load if the sample's sign bit differs from the channel's stored previous sign.
- R3: On a load with detection enabled, the channel flag is 1 in the cycle after the load if all bits below the selected width are zero; bits at or above the selected width do not take part in this test.
- R4: The sign bit is bit 7 for width code 0, bit 15 for code 1, bit 23 for code 2 and bit 31 for code 3.
- R5: With detection disabled for a channel, a load of that channel never sets its flag, but it still updates that channel's stored previous sign.
- R6: Each channel keeps its own previous sign. A load tagged right (load_right=1) changes only the right state, and a load tagged left (load_right=0) changes only the left state.
- R7: A set flag stays 1 until a clear pulse for that channel; with a clear pulse and no event, the flag is 0 in the next cycle.
- R8: When an event and a clear pulse for the same channel fall in the same cycle, the flag is 1 afterwards.
- R9: The interrupt output is 1 exactly when (left flag and left interrupt enable) or (right flag and right interrupt enable) holds, with the enables sampled one cycle earlier than the flags are shown.
- R10: In a cycle without a load, no flag is set and no stored previous sign changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | A sample is loaded into the transmit shift buffer this cycle |
| load_data | input | 32 | The sample being loaded |
| load_right | input | 1 | Channel tag: 0 left, 1 right |
| word_width | input | 2 | Width code: 0=8, 1=16, 2=24, 3=32 bits |
| det_en_left | input | 1 | Detection enable, left channel |
| det_en_right | input | 1 | Detection enable, right channel |
| irq_en_left | input | 1 | Interrupt enable, left flag |
| irq_en_right | input | 1 | Interrupt enable, right flag |
| clr_left | input | 1 | Write-1 clear pulse, left flag |
| clr_right | input | 1 | Write-1 clear pulse, right flag |
| flag_left | output | 1 | Sticky left zero-cross flag |
| flag_right | output | 1 | Sticky right zero-cross flag |
| irq | output | 1 | Combined registered interrupt |

## Verification
A detected crossing and a software clear of the same flag can land in the same cycle. The bench provokes this by raising the clear pulse together with a load whose sign differs from the stored sign. The flag must read 1 afterwards and stay set until a later clear pulse with no event. A behavioural reference model, updated on every clock, judges this collision and every other cycle. The model applies the clear first and then the set, and the bench compares both flags and the interrupt with it after each edge.

// File: rtl/txzc_pkg.sv
package txzc_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_t;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/txzc_sample_probe.sv
module txzc_sample_probe #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W  = LANE_W * LANES,
  localparam int WW_BITS = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [WW_BITS-1:0] width,
  output logic               sign,
  output logic               all_zero
);
  logic [LANES-1:0] lane_zero;
  logic [LANES-1:0] lane_top;
  logic [LANES-1:0] lane_used;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_zero[l] = (data[l*LANE_W +: LANE_W] == '0);
    assign lane_top[l]  = data[l*LANE_W + LANE_W - 1];
    assign lane_used[l] = (l <= int'(width));
  end

  always_comb begin
    sign     = 1'b0;
    all_zero = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (lane_used[l]) begin
        all_zero = all_zero & lane_zero[l];
      end
      if (l == int'(width)) begin
        sign = lane_top[l];
      end
    end
  end
endmodule

// File: rtl/txzc_lane_tracker.sv
module txzc_lane_tracker (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic sign,
  input  logic all_zero,
  input  logic det_en,
  input  logic clr,
  output logic flag,
  output logic flag_nxt
);
  logic prev_sign;
  logic hit;

  assign hit      = take && det_en && ((sign != prev_sign) || all_zero);
  assign flag_nxt = hit | (flag & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sign <= 1'b0;
      flag      <= 1'b0;
    end else begin
      if (take) begin
        prev_sign <= sign;
      end
      flag <= flag_nxt;
    end
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (rst) (flag && !clr) |=> flag); // R7
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst) (clr && !hit) |=> !flag); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) hit |=> flag); // R8
  AST_PREV_HELD: assert property (@(posedge clk) disable iff (rst) !take |=> $stable(prev_sign)); // R10
  AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (rst) take |=> (prev_sign == $past(sign))); // R5
  AST_NO_LOAD_NO_SET: assert property (@(posedge clk) disable iff (rst) (!take && !flag) |=> !flag); // R10
endmodule

// File: rtl/txzc_monitor.sv
module txzc_monitor #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W  = LANE_W * LANES,
  localparam int WW_BITS = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_valid,
  input  logic [DATA_W-1:0]  load_data,
  input  logic               load_right,
  input  logic [WW_BITS-1:0] word_width,
  input  logic               det_en_left,
  input  logic               det_en_right,
  input  logic               irq_en_left,
  input  logic               irq_en_right,
  input  logic               clr_left,
  input  logic               clr_right,
  output logic               flag_left,
  output logic               flag_right,
  output logic               irq
);
  import txzc_pkg::*;

  logic sample_sign;
  logic sample_zero;
  logic [NUM_CH-1:0] det_en_v;
  logic [NUM_CH-1:0] irq_en_v;
  logic [NUM_CH-1:0] clr_v;
  logic [NUM_CH-1:0] flag_v;
  logic [NUM_CH-1:0] flag_nxt_v;
  chan_t             tag;

  assign det_en_v = {det_en_right, det_en_left};
  assign irq_en_v = {irq_en_right, irq_en_left};
  assign clr_v    = {clr_right, clr_left};
  assign tag      = chan_t'(load_right);

  txzc_sample_probe #(
    .LANE_W(LANE_W),
    .LANES (LANES)
  ) u_probe (
    .data    (load_data),
    .width   (word_width),
    .sign    (sample_sign),
    .all_zero(sample_zero)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic take_c;
    assign take_c = load_valid && (tag == chan_t'(c));

    txzc_lane_tracker u_trk (
      .clk     (clk),
      .rst     (rst),
      .take    (take_c),
      .sign    (sample_sign),
      .all_zero(sample_zero),
      .det_en  (det_en_v[c]),
      .clr     (clr_v[c]),
      .flag    (flag_v[c]),
      .flag_nxt(flag_nxt_v[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= |(flag_nxt_v & irq_en_v);
    end
  end

  assign flag_left  = flag_v[0];
  assign flag_right = flag_v[1];

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst) irq |-> (flag_left || flag_right)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst) (!irq_en_left && !irq_en_right) |=> !irq); // R9
  AST_LEFT_UNTOUCHED: assert property (@(posedge clk) disable iff (rst) (load_right && !flag_left && !clr_left) |=> !flag_left); // R6
endmodule

// File: tb/txzc_monitor_test.sv
module txzc_monitor_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        load_valid;
  logic [31:0] load_data;
  logic        load_right;
  logic [1:0]  word_width;
  logic [1:0]  den;
  logic [1:0]  ien;
  logic [1:0]  clr;
  logic        flag_left, flag_right, irq;

  int checks = 0;
  int fails  = 0;
  bit m_prev [2];
  bit m_flag [2];
  bit m_irq;

  always #10 clk = ~clk;

  txzc_monitor uut (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_data(load_data),
    .load_right(load_right), .word_width(word_width),
    .det_en_left(den[0]), .det_en_right(den[1]),
    .irq_en_left(ien[0]), .irq_en_right(ien[1]),
    .clr_left(clr[0]), .clr_right(clr[1]),
    .flag_left(flag_left), .flag_right(flag_right), .irq(irq)
  );

  task automatic cmp(string tag, string what, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    bit nf [2];
    @(posedge clk);
    if (rst) begin
      m_prev = '{0, 0};
      m_flag = '{0, 0};
      m_irq  = 0;
    end else begin
      for (int c = 0; c < 2; c++) nf[c] = m_flag[c] & ~clr[c];
      if (load_valid) begin
        int ch;
        int w;
        bit s;
        bit z;
        ch = load_right ? 1 : 0;
        w  = (int'(word_width) + 1) * 8;
        s  = load_data[w-1];
        z  = 1;
        for (int i = 0; i < w; i++) if (load_data[i]) z = 0;
        if (den[ch] && ((s != m_prev[ch]) || z)) nf[ch] = 1;
        m_prev[ch] = s;
      end
      m_irq  = (nf[0] & ien[0]) | (nf[1] & ien[1]);
      m_flag = nf;
    end
    #2;
    cmp(tag, "flag_left", flag_left, m_flag[0]);
    cmp(tag, "flag_right", flag_right, m_flag[1]);
    cmp(tag, "irq", irq, m_irq);
  endtask

  task automatic load(bit right, logic [31:0] d, string tag);
    load_valid = 1'b1;
    load_right = right;
    load_data  = d;
    step(tag);
    load_valid = 1'b0;
    load_data  = 32'h5555_5555;
  endtask

  task automatic clear(logic [1:0] which, string tag);
    clr = which;
    step(tag);
    clr = 2'b00;
  endtask

  task automatic expect_flags(string tag, bit l, bit r);
    cmp(tag, "flag_left direct", flag_left, l);
    cmp(tag, "flag_right direct", flag_right, r);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; load_valid = 1'b0; load_data = '0; load_right = 1'b0;
    word_width = 2'd3; den = 2'b00; ien = 2'b00; clr = 2'b00;
    repeat (3) step("R1");
    rst = 1'b0;
    step("R1");
    expect_flags("R1", 0, 0);

    den = 2'b11;
    load(0, 32'h0000_0001, "R2");            // same sign, non-zero
    expect_flags("R2", 0, 0);
    load(0, 32'h8000_0000, "R2");            // sign 0 -> 1
    expect_flags("R2", 1, 0);
    repeat (3) step("R7");
    expect_flags("R7", 1, 0);
    clear(2'b01, "R7");
    expect_flags("R7", 0, 0);
    load(0, 32'h8000_0001, "R2");            // sign stays 1
    expect_flags("R2", 0, 0);

    word_width = 2'd0;
    load(1, 32'h0000_0080, "R4");            // bit7 set, right prev 0
    expect_flags("R4", 0, 1);
    clear(2'b10, "R7");
    load(1, 32'h0000_7F81, "R4");            // bit15 ignored at width 8
    expect_flags("R4", 0, 0);
    load(1, 32'hFFFF_FF00, "R3");            // low byte zero
    expect_flags("R3", 0, 1);
    clear(2'b10, "R7");
    word_width = 2'd1;
    load(1, 32'h0000_8000, "R4");            // bit15 set
    expect_flags("R4", 0, 1);
    clear(2'b10, "R7");
    word_width = 2'd2;
    load(1, 32'h0000_8000, "R4");            // bit23 clear -> sign 0 vs prev 1
    expect_flags("R4", 0, 1);
    clear(2'b10, "R7");
    load(1, 32'hFF00_0000, "R3");            // 24-bit zero, top byte ignored
    expect_flags("R3", 0, 1);
    clear(2'b10, "R7");
    load(1, 32'h0080_0001, "R4");            // bit23 set
    expect_flags("R4", 0, 1);
    clear(2'b10, "R7");

    word_width = 2'd3;
    den = 2'b10;
    load(0, 32'h0000_0000, "R5");            // zero but disabled
    expect_flags("R5", 0, 0);
    den = 2'b11;
    load(0, 32'h0000_0002, "R5");            // prev became 0 -> no event
    expect_flags("R5", 0, 0);

    load(0, 32'h8000_0004, "R6");            // left prev -> 1, sets
    clear(2'b01, "R7");
    load(1, 32'h0000_0010, "R6");            // right sign 0
    load(1, 32'h0000_0020, "R6");
    expect_flags("R6", 0, 1);
    clear(2'b10, "R7");
    load(0, 32'h8000_0008, "R6");            // left prev still 1
    expect_flags("R6", 0, 0);

    repeat (4) step("R10");
    expect_flags("R10", 0, 0);

    clr = 2'b01;
    load(0, 32'h0000_0100, "R8");            // sign 1 -> 0 with clear
    clr = 2'b00;
    expect_flags("R8", 1, 0);
    step("R8");
    expect_flags("R8", 1, 0);

    ien = 2'b01;
    step("R9");
    cmp("R9", "irq direct", irq, 1'b1);
    ien = 2'b10;
    step("R9");
    cmp("R9", "irq direct", irq, 1'b0);
    load(1, 32'h8000_0000, "R9");
    cmp("R9", "irq direct", irq, 1'b1);
    clear(2'b11, "R9");
    cmp("R9", "irq direct", irq, 1'b0);
    ien = 2'b11;
    load(0, 32'h0000_0000, "R9");
    cmp("R9", "irq direct", irq, 1'b1);
    clear(2'b01, "R7");
    expect_flags("R7", 0, 0);

    rst = 1'b1;
    step("R1");
    rst = 1'b0;
    load(1, 32'h0000_0001, "R1");            // prev reset to 0: no event
    expect_flags("R1", 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule